// File: doc/BRIEF.md
# Tile-Overlapped Wavelet Filter Sequencer

This block is the control unit of a tiled, line-based two-dimensional wavelet engine. It owns no data path. It produces enable lines, state codes and tile indices for four filter engines. The first-level row filter turns a tile's pixels into low and high row bands. The deeper-level row filter re-splits low-low output along rows at each further level. Two column filters work in lock-step on the low and the high row bands. Tile size `TILE_N`, the longest filter length `TAPS`, the level count `LEVELS` and the tiling factor `TILE_LOG` are parameters. An image is split into `4**TILE_LOG` tiles, and `LEVELS` must be at least 2.

A one-cycle `start` launches a whole image. The first-level row filter runs for `TILE_N*TILE_N/2` cycles per tile. The column-side filters wait for the first column window to fill. From then on they process every tile back to back with no idle gap, and handle the levels of a tile in ascending order. When the first-level row filter finishes a tile, it moves on to the next tile at once. The only exception is when the column side has not yet begun the tile it just finished; it then holds in a wait state. This bounds the lead of the row filter to one tile, which overlaps most of the row work of one tile with the column work of the one before it.

Top module: `tile_wavelet_sched`

## Requirements
- R1: While reset is asserted and after it until `start`, all enables, tile-start strobes and `done` are 0, every state output is idle (0), and the tile indices read 0.
- R2: A `start` sampled while idle makes the first-level row filter run (`lrow_en`=1, state code 2) in cycles 0 to P-1 after that edge, with P = TILE_N*TILE_N/2.
- R3: The column-side filters report wait (code 1) for the first C1 = TILE_N*(TAPS-1)/4 + 1 cycles after start, and are first enabled in cycle C1.
- R4: Row tile t+1 begins in cycle max(S_t + P, C1 + t*D), with S_t the start cycle of row tile t. In any gap the row filter reports wait (code 1). After its last tile it reports idle.
- R5: The column filters stay enabled without a break from cycle C1 to cycle C1 + T*D - 1, where T = 4**TILE_LOG. `col_tile` equals the count of whole D-cycle periods elapsed since C1.
- R6: Within a column tile, level 1 lasts P cycles. Each level a ≥ 2 lasts m*m/2 + m*(TAPS-1)/4 + 1 cycles with m = TILE_N/2**(a-1). Levels run in ascending order on `col_level`, and D is the sum of these lengths.
- R7: The deeper-level row filter is enabled exactly when the column filters are enabled and `col_level` is below LEVELS. Otherwise it reports wait (code 1) while column work remains and idle (code 0) after it.
- R8: The low-band and high-band column filters always show identical enables and state codes.
- R9: `done` is high for exactly cycle C1 + T*D, after which every filter reports idle.
- R10: `start` has no effect while any filter is busy; the running schedule continues unchanged.
- R11: `lrow_tile_start` pulses in the first cycle of each row tile, with `lrow_tile` giving that tile's index. `col_tile_start` pulses in cycle C1 + t*D for each t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | launch one image of T tiles |
| lrow_en | output | 1 | enable of the first-level row filter |
| hrow_en | output | 1 | enable of the deeper-level row filter |
| vlo_en | output | 1 | enable of the column filter on the low row band |
| vhi_en | output | 1 | enable of the column filter on the high row band |
| lrow_state | output | 2 | 0 idle, 1 wait, 2 run |
| hrow_state | output | 2 | 0 idle, 1 wait, 2 run |
| vlo_state | output | 2 | 0 idle, 1 wait, 2 run |
| vhi_state | output | 2 | 0 idle, 1 wait, 2 run |
| lrow_tile_start | output | 1 | first cycle of a row tile |
| col_tile_start | output | 1 | first cycle of a column tile |
| lrow_tile | output | TW | tile being row filtered |
| col_tile | output | TW | tile being column filtered |
| col_level | output | LW | decomposition level in column work |
| done | output | 1 | one-cycle pulse after the last tile |

## Verification
The bench builds two copies side by side. The first uses 16-pixel tiles, 5 taps and 3 levels. Its row filter never has to wait, and all three level segments and the level-to-level hand-overs fall inside each column tile. The second uses 8-pixel tiles, 9 taps and 2 levels. Its column tile (49 cycles) is long enough against its row tile (32 cycles) that the row filter must enter the wait state twice, so it exercises the gating rule of R4. Both copies run four tiles and are compared every cycle against closed-form start times. A second launch holds `start` high during the busy period.

// File: rtl/tile_wavelet_sched.sv
module tile_wavelet_sched #(
  parameter int TILE_N   = 16,
  parameter int TAPS     = 5,
  parameter int LEVELS   = 3,
  parameter int TILE_LOG = 1,
  localparam int TILES   = 1 << (2 * TILE_LOG),
  localparam int TW      = (TILES > 1) ? $clog2(TILES) : 1,
  localparam int LW      = $clog2(LEVELS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          lrow_en,
  output logic          hrow_en,
  output logic          vlo_en,
  output logic          vhi_en,
  output logic [1:0]    lrow_state,
  output logic [1:0]    hrow_state,
  output logic [1:0]    vlo_state,
  output logic [1:0]    vhi_state,
  output logic          lrow_tile_start,
  output logic          col_tile_start,
  output logic [TW-1:0] lrow_tile,
  output logic [TW-1:0] col_tile,
  output logic [LW-1:0] col_level,
  output logic          done
);

  localparam int FILL  = TILE_N * (TAPS - 1) / 4 + 1;
  localparam int ROWP  = TILE_N * TILE_N / 2;
  localparam int NSEG  = 1 << LW;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_WAIT = 2'd1, S_RUN = 2'd2} st_t;

  logic [31:0] seg_len [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    if (g == 1) begin : g_first
      assign seg_len[g] = 32'(ROWP);
    end else if (g >= 2 && g <= LEVELS) begin : g_deep
      localparam int M = TILE_N >> (g - 1);
      assign seg_len[g] = 32'(M * M / 2 + M * (TAPS - 1) / 4 + 1);
    end else begin : g_unused
      assign seg_len[g] = 32'd1;
    end
  end

  st_t           lr_st, lr_st_n, cl_st, cl_st_n;
  logic [31:0]   lr_cnt, lr_cnt_n, cl_cnt, cl_cnt_n;
  logic [TW-1:0] lr_tile_n, cl_tile_n;
  logic [LW-1:0] cl_lvl_n;
  logic          lts_n, cts_n, done_n, go, gate;

  assign go = start && lr_st == S_IDLE && cl_st == S_IDLE;

  always_comb begin
    cl_st_n   = cl_st;
    cl_cnt_n  = cl_cnt;
    cl_lvl_n  = col_level;
    cl_tile_n = col_tile;
    cts_n     = 1'b0;
    done_n    = 1'b0;
    case (cl_st)
      S_IDLE: if (go) begin
        cl_st_n  = S_WAIT;
        cl_cnt_n = '0;
      end
      S_WAIT: if (cl_cnt == 32'(FILL - 1)) begin
        cl_st_n   = S_RUN;
        cl_cnt_n  = '0;
        cl_lvl_n  = LW'(1);
        cl_tile_n = '0;
        cts_n     = 1'b1;
      end else begin
        cl_cnt_n = cl_cnt + 32'd1;
      end
      S_RUN: if (cl_cnt == seg_len[col_level] - 32'd1) begin
        cl_cnt_n = '0;
        if (col_level == LW'(LEVELS)) begin
          if (col_tile == TW'(TILES - 1)) begin
            cl_st_n = S_IDLE;
            done_n  = 1'b1;
          end else begin
            cl_tile_n = col_tile + 1'b1;
            cl_lvl_n  = LW'(1);
            cts_n     = 1'b1;
          end
        end else begin
          cl_lvl_n = col_level + 1'b1;
        end
      end else begin
        cl_cnt_n = cl_cnt + 32'd1;
      end
      default: cl_st_n = S_IDLE;
    endcase
  end

  assign gate = (cl_st_n == S_RUN) && (cl_tile_n >= lrow_tile);

  always_comb begin
    lr_st_n   = lr_st;
    lr_cnt_n  = lr_cnt;
    lr_tile_n = lrow_tile;
    lts_n     = 1'b0;
    case (lr_st)
      S_IDLE: if (go) begin
        lr_st_n   = S_RUN;
        lr_cnt_n  = '0;
        lr_tile_n = '0;
        lts_n     = 1'b1;
      end
      S_RUN: if (lr_cnt == 32'(ROWP - 1)) begin
        lr_cnt_n = '0;
        if (lrow_tile == TW'(TILES - 1)) begin
          lr_st_n = S_IDLE;
        end else if (gate) begin
          lr_tile_n = lrow_tile + 1'b1;
          lts_n     = 1'b1;
        end else begin
          lr_st_n = S_WAIT;
        end
      end else begin
        lr_cnt_n = lr_cnt + 32'd1;
      end
      S_WAIT: if (gate) begin
        lr_st_n   = S_RUN;
        lr_tile_n = lrow_tile + 1'b1;
        lts_n     = 1'b1;
      end
      default: lr_st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_st           <= S_IDLE;
      cl_st           <= S_IDLE;
      lr_cnt          <= '0;
      cl_cnt          <= '0;
      lrow_tile       <= '0;
      col_tile        <= '0;
      col_level       <= '0;
      lrow_tile_start <= 1'b0;
      col_tile_start  <= 1'b0;
      done            <= 1'b0;
    end else begin
      lr_st           <= lr_st_n;
      cl_st           <= cl_st_n;
      lr_cnt          <= lr_cnt_n;
      cl_cnt          <= cl_cnt_n;
      lrow_tile       <= lr_tile_n;
      col_tile        <= cl_tile_n;
      col_level       <= cl_lvl_n;
      lrow_tile_start <= lts_n;
      col_tile_start  <= cts_n;
      done            <= done_n;
    end
  end

  assign lrow_en    = lr_st == S_RUN;
  assign vlo_en     = cl_st == S_RUN;
  assign vhi_en     = cl_st == S_RUN;
  assign hrow_en    = vlo_en && col_level != LW'(LEVELS);
  assign lrow_state = lr_st;
  assign vlo_state  = cl_st;
  assign vhi_state  = cl_st;
  assign hrow_state = hrow_en ? S_RUN : (cl_st != S_IDLE ? S_WAIT : S_IDLE);

  // R3
  fill_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vlo_en) |-> $past(vlo_state) == S_WAIT);

  // R4
  row_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lrow_tile_start && lrow_tile != '0) |-> (vlo_en && col_tile >= lrow_tile - 1'b1));

  // R5
  col_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vlo_en) |-> done);

  // R6
  level_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vlo_en && $past(vlo_en) && col_level != $past(col_level)) |->
      (col_level == $past(col_level) + 1'b1 ||
       (col_level == LW'(1) && $past(col_level) == LW'(LEVELS))));

  // R6
  tile_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_tile_start |-> (vlo_en && col_level == LW'(1)));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!lrow_en && !vlo_en && lrow_state == S_IDLE));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_tile_wavelet_sched.sv
`timescale 1ns/1ps
module sim_tile_wavelet_sched;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  int   checks = 0;
  int   errors = 0;

  always #4 clk = ~clk;

  logic       a_lr, a_hr, a_vl, a_vh, a_lts, a_cts, a_dn;
  logic [1:0] a_lrs, a_hrs, a_vls, a_vhs, a_lt, a_ct, a_lvl;
  logic       b_lr, b_hr, b_vl, b_vh, b_lts, b_cts, b_dn;
  logic [1:0] b_lrs, b_hrs, b_vls, b_vhs, b_lt, b_ct, b_lvl;

  tile_wavelet_sched u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .lrow_en(a_lr), .hrow_en(a_hr), .vlo_en(a_vl), .vhi_en(a_vh),
    .lrow_state(a_lrs), .hrow_state(a_hrs), .vlo_state(a_vls), .vhi_state(a_vhs),
    .lrow_tile_start(a_lts), .col_tile_start(a_cts),
    .lrow_tile(a_lt), .col_tile(a_ct), .col_level(a_lvl), .done(a_dn));

  tile_wavelet_sched #(.TILE_N(8), .TAPS(9), .LEVELS(2), .TILE_LOG(1)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .lrow_en(b_lr), .hrow_en(b_hr), .vlo_en(b_vl), .vhi_en(b_vh),
    .lrow_state(b_lrs), .hrow_state(b_hrs), .vlo_state(b_vls), .vhi_state(b_vhs),
    .lrow_tile_start(b_lts), .col_tile_start(b_cts),
    .lrow_tile(b_lt), .col_tile(b_ct), .col_level(b_lvl), .done(b_dn));

  typedef struct packed {
    logic lr, hr, vc, dn, lts, cts;
    logic [1:0] lrs, hrs, vcs;
    logic [7:0] lvl, lt, ct;
  } exp_t;

  // cycle, row en, column en, deeper row en, level (0 = skip), column tile (-1 = skip)
  localparam int TBL [10][6] = '{
    '{0,   1, 0, 0, 0, -1},
    '{16,  1, 0, 0, 0, -1},
    '{17,  1, 1, 1, 1,  0},
    '{127, 1, 1, 1, 1,  0},
    '{128, 1, 1, 1, 1,  0},
    '{145, 1, 1, 1, 2,  0},
    '{186, 1, 1, 0, 3,  0},
    '{199, 1, 1, 1, 1,  1},
    '{512, 0, 1, 1, 2,  2},
    '{744, 0, 1, 0, 3,  3}
  };

  function automatic exp_t model(int n, int k, int j, int tiles, int cyc);
    exp_t e;
    int c1, p, d, tot, ds, rem;
    int f1s [17];
    bit found;
    e = '0;
    c1 = n * (k - 1) / 4 + 1;
    p = n * n / 2;
    d = p;
    for (int a = 2; a <= j; a++) begin
      int m;
      m = n >> (a - 1);
      d += m * m / 2 + m * (k - 1) / 4 + 1;
    end
    tot = c1 + tiles * d;
    f1s[0] = 0;
    for (int t = 0; t < tiles - 1; t++) begin
      ds = c1 + t * d;
      f1s[t+1] = (f1s[t] + p > ds) ? f1s[t] + p : ds;
    end
    for (int t = 0; t < tiles; t++) begin
      if (cyc >= f1s[t] && cyc < f1s[t] + p) begin
        e.lr = 1'b1;
        e.lt = 8'(t);
      end
      if (cyc == f1s[t]) e.lts = 1'b1;
      if (cyc == c1 + t * d) e.cts = 1'b1;
    end
    e.lrs = e.lr ? 2'd2 : (cyc < f1s[tiles-1] ? 2'd1 : 2'd0);
    e.dn = (cyc == tot);
    if (cyc >= c1 && cyc < tot) begin
      e.vc = 1'b1;
      e.ct = 8'((cyc - c1) / d);
      rem = (cyc - c1) % d;
      found = 1'b0;
      if (rem < p) begin
        e.lvl = 8'd1;
        found = 1'b1;
      end else begin
        rem -= p;
      end
      for (int a = 2; a <= j; a++) begin
        int m, sa;
        m = n >> (a - 1);
        sa = m * m / 2 + m * (k - 1) / 4 + 1;
        if (!found && rem < sa) begin
          e.lvl = 8'(a);
          found = 1'b1;
        end else if (!found) begin
          rem -= sa;
        end
      end
    end
    e.hr  = e.vc && (e.lvl != 8'(j));
    e.vcs = e.vc ? 2'd2 : (cyc < c1 ? 2'd1 : 2'd0);
    e.hrs = e.hr ? 2'd2 : (cyc < tot ? 2'd1 : 2'd0);
    return e;
  endfunction

  task automatic chk(input string req, input string inst, input int cyc,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %0d expected %0d", req, inst, cyc, act, exp);
    end
  endtask

  task automatic check_inst(input string inst, input int cyc, input exp_t e,
      input logic lr, input logic hr, input logic vl, input logic vh,
      input logic lts, input logic cts, input logic dn,
      input logic [1:0] lrs, input logic [1:0] hrs, input logic [1:0] vls,
      input logic [1:0] vhs, input int lt, input int ct, input int lvl);
    chk("R2", inst, cyc, int'(lr), int'(e.lr));
    chk("R4", inst, cyc, int'(lrs), int'(e.lrs));
    chk("R3", inst, cyc, int'(vls), int'(e.vcs));
    chk("R5", inst, cyc, int'(vl), int'(e.vc));
    chk("R8", inst, cyc, int'(vh), int'(vl));
    chk("R8", inst, cyc, int'(vhs), int'(vls));
    chk("R7", inst, cyc, int'(hr), int'(e.hr));
    chk("R7", inst, cyc, int'(hrs), int'(e.hrs));
    chk("R9", inst, cyc, int'(dn), int'(e.dn));
    chk("R11", inst, cyc, int'(lts), int'(e.lts));
    chk("R11", inst, cyc, int'(cts), int'(e.cts));
    if (e.lr) chk("R11", inst, cyc, lt, int'(e.lt));
    if (e.vc) begin
      chk("R5", inst, cyc, ct, int'(e.ct));
      chk("R6", inst, cyc, lvl, int'(e.lvl));
    end
  endtask

  task automatic check_reset(input string tag);
    chk("R1", tag, 0, int'({a_lr, a_hr, a_vl, a_vh, a_lts, a_cts, a_dn}), 0);
    chk("R1", tag, 0, int'({a_lrs, a_hrs, a_vls, a_vhs}), 0);
    chk("R1", tag, 0, int'({a_lt, a_ct}), 0);
    chk("R1", tag, 0, int'({b_lr, b_hr, b_vl, b_vh, b_lts, b_cts, b_dn}), 0);
    chk("R1", tag, 0, int'({b_lrs, b_hrs, b_vls, b_vhs}), 0);
    chk("R1", tag, 0, int'({b_lt, b_ct}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tp;
    tp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset("in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_reset("after reset");
    for (int run = 0; run < 2; run++) begin
      start = 1'b1;
      for (int cyc = 0; cyc < 760; cyc++) begin
        exp_t ea, eb;
        @(negedge clk);
        ea = model(16, 5, 3, 4, cyc);
        eb = model(8, 9, 2, 4, cyc);
        check_inst("u0", cyc, ea, a_lr, a_hr, a_vl, a_vh, a_lts, a_cts, a_dn,
                   a_lrs, a_hrs, a_vls, a_vhs, int'(a_lt), int'(a_ct), int'(a_lvl));
        check_inst("u1", cyc, eb, b_lr, b_hr, b_vl, b_vh, b_lts, b_cts, b_dn,
                   b_lrs, b_hrs, b_vls, b_vhs, int'(b_lt), int'(b_ct), int'(b_lvl));
        if (run == 0 && tp < 10 && TBL[tp][0] == cyc) begin
          chk("R6", "table", cyc, int'(a_lr), TBL[tp][1]);
          chk("R6", "table", cyc, int'(a_vl), TBL[tp][2]);
          chk("R6", "table", cyc, int'(a_hr), TBL[tp][3]);
          if (TBL[tp][4] != 0) chk("R6", "table", cyc, int'(a_lvl), TBL[tp][4]);
          if (TBL[tp][5] >= 0) chk("R6", "table", cyc, int'(a_ct), TBL[tp][5]);
          tp++;
        end
        // R10: extra start pulses land while both copies are busy
        start = (run == 1 && cyc < 2) || (run == 0 && cyc == 150);
      end
    end
    chk("R6", "table rows walked", 0, tp, 10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule